// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block chooses, among a set of interrupt sources, the single request a processor should service next. For each source it receives four request-qualifying bits (a pending bit, a software force bit, an enable bit and a mask bit) together with a per-source priority level. From these it works out which sources may compete, picks the strongest, and presents the winner's level, an exception vector number derived from the winner's index, and a flag saying whether anything won at all.

The selection is done in one clock cycle by a balanced tree of two-input comparators. The results are registered, so a change on the inputs appears at the outputs after the next rising clock edge. The register file, the bus decoding and the acknowledge cycle all sit outside this block. Their state arrives here as flat vectors, and the registered outputs go to the processor's interrupt-level input.

Top module: `irq_level_resolver`

## Requirements
- R1: Source i competes only when (pend_i[i] OR force_i[i]) AND en_i[i] AND NOT mask_i[i]. A pending bit on a disabled or masked source has no effect on the outputs.
- R2: The winner is the competing source with the largest level. Source i's level is the unsigned field lvl_i[i*8 +: 8] at the default width.
- R3: When several competing sources share the largest level, the one with the highest index wins.
- R4: While valid_o is 1, vector_o equals the winner's index plus 64, so it lies in 64..127 for 64 sources.
- R5: When no source competes, level_o is 0, vector_o is 24 and valid_o is 0.
- R6: The outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R7: valid_o is 1 exactly when at least one source competed at the previous edge.
- R8: A synchronous active-high rst sets valid_o to 0, level_o to 0 and vector_o to 24 at the next edge, whatever the inputs are.
- R9: A competing source whose level is 0 still wins when it is alone. The outputs are then valid_o 1, level_o 0 and vector_o equal to its index plus 64.
- R10: A set mask bit overrides the force bit, so a forced but masked source does not compete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | N_SRC | Pending request per source |
| force_i | input | N_SRC | Software-forced request per source |
| en_i | input | N_SRC | Source enable |
| mask_i | input | N_SRC | Source mask, 1 blocks the source |
| lvl_i | input | N_SRC*LVL_W | Packed priority levels, source i at [i*LVL_W +: LVL_W] |
| valid_o | output | 1 | A source won |
| level_o | output | LVL_W | Winning level, 0 when none |
| vector_o | output | VEC_W | Winner index plus VEC_BASE, or SPUR_VEC when none |

## Verification
The bench builds the block with its default values: 64 sources, 8-bit levels and an 8-bit vector. This exercises the full six-stage comparison tree, the highest index 63 and the top vector value 127. Every source's level is driven independently. Random runs use only four level values, so ties meet at every depth of the tree and each merge must apply the higher-index rule. All of these runs are compared with a plain upward scan.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  parameter int unsigned DEF_SRC      = 64;
  parameter int unsigned DEF_LVL_W    = 8;
  parameter int unsigned DEF_VEC_W    = 8;
  parameter int unsigned DEF_VEC_BASE = 64;
  parameter int unsigned DEF_SPUR_VEC = 24;
endpackage

// File: rtl/irq_eligible.sv
module irq_eligible #(
  parameter int unsigned N = irq_res_pkg::DEF_SRC
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] frc,
  input  logic [N-1:0] en,
  input  logic [N-1:0] msk,
  output logic [N-1:0] elig
);
  for (genvar i = 0; i < N; i++) begin : g_src
    assign elig[i] = (pend[i] | frc[i]) & en[i] & ~msk[i];
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned LVL_W = irq_res_pkg::DEF_LVL_W,
  parameter int unsigned IDX_W = 6
) (
  input  logic             lo_vld,
  input  logic [LVL_W-1:0] lo_lvl,
  input  logic [IDX_W-1:0] lo_idx,
  input  logic             hi_vld,
  input  logic [LVL_W-1:0] hi_lvl,
  input  logic [IDX_W-1:0] hi_idx,
  output logic             out_vld,
  output logic [LVL_W-1:0] out_lvl,
  output logic [IDX_W-1:0] out_idx
);
  logic take_hi;

  // the upper half holds the higher indices, so ties go to it
  assign take_hi = hi_vld && (!lo_vld || (hi_lvl >= lo_lvl));
  assign out_vld = lo_vld | hi_vld;
  assign out_lvl = take_hi ? hi_lvl : lo_lvl;
  assign out_idx = take_hi ? hi_idx : lo_idx;
endmodule

// File: rtl/irq_tree.sv
module irq_tree #(
  parameter int unsigned N     = irq_res_pkg::DEF_SRC,
  parameter int unsigned LVL_W = irq_res_pkg::DEF_LVL_W
) (
  input  logic [N-1:0]       elig,
  input  logic [N*LVL_W-1:0] lvl_flat,
  output logic               any,
  output logic [LVL_W-1:0]   win_lvl,
  output logic [$clog2(N)-1:0] win_idx
);
  localparam int unsigned IDX_W = $clog2(N);
  localparam int unsigned DEPTH = $clog2(N);

  logic             leaf_vld [N];
  logic [LVL_W-1:0] leaf_lvl [N];
  logic [IDX_W-1:0] leaf_idx [N];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign leaf_vld[i] = elig[i];
    assign leaf_lvl[i] = lvl_flat[i*LVL_W +: LVL_W];
    assign leaf_idx[i] = IDX_W'(i);
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    localparam int unsigned W = N >> (s + 1);
    logic             q_vld [W];
    logic [LVL_W-1:0] q_lvl [W];
    logic [IDX_W-1:0] q_idx [W];

    for (genvar j = 0; j < W; j++) begin : g_node
      logic             a_vld, b_vld;
      logic [LVL_W-1:0] a_lvl, b_lvl;
      logic [IDX_W-1:0] a_idx, b_idx;

      if (s == 0) begin : g_from_leaf
        assign a_vld = leaf_vld[2*j];
        assign a_lvl = leaf_lvl[2*j];
        assign a_idx = leaf_idx[2*j];
        assign b_vld = leaf_vld[2*j+1];
        assign b_lvl = leaf_lvl[2*j+1];
        assign b_idx = leaf_idx[2*j+1];
      end else begin : g_from_stage
        assign a_vld = g_stage[s-1].q_vld[2*j];
        assign a_lvl = g_stage[s-1].q_lvl[2*j];
        assign a_idx = g_stage[s-1].q_idx[2*j];
        assign b_vld = g_stage[s-1].q_vld[2*j+1];
        assign b_lvl = g_stage[s-1].q_lvl[2*j+1];
        assign b_idx = g_stage[s-1].q_idx[2*j+1];
      end

      irq_merge #(.LVL_W(LVL_W), .IDX_W(IDX_W)) u_merge (
        .lo_vld (a_vld), .lo_lvl (a_lvl), .lo_idx (a_idx),
        .hi_vld (b_vld), .hi_lvl (b_lvl), .hi_idx (b_idx),
        .out_vld(q_vld[j]), .out_lvl(q_lvl[j]), .out_idx(q_idx[j])
      );
    end
  end

  assign any     = g_stage[DEPTH-1].q_vld[0];
  assign win_lvl = g_stage[DEPTH-1].q_lvl[0];
  assign win_idx = g_stage[DEPTH-1].q_idx[0];
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver #(
  parameter int unsigned N_SRC    = irq_res_pkg::DEF_SRC,
  parameter int unsigned LVL_W    = irq_res_pkg::DEF_LVL_W,
  parameter int unsigned VEC_W    = irq_res_pkg::DEF_VEC_W,
  parameter int unsigned VEC_BASE = irq_res_pkg::DEF_VEC_BASE,
  parameter int unsigned SPUR_VEC = irq_res_pkg::DEF_SPUR_VEC
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC-1:0]       force_i,
  input  logic [N_SRC-1:0]       en_i,
  input  logic [N_SRC-1:0]       mask_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  output logic                   valid_o,
  output logic [LVL_W-1:0]       level_o,
  output logic [VEC_W-1:0]       vector_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] SPUR_V = VEC_W'(SPUR_VEC);
  localparam logic [VEC_W-1:0] LAST_V = VEC_W'(VEC_BASE + N_SRC - 1);

  logic [N_SRC-1:0] elig;
  logic             any;
  logic [LVL_W-1:0] win_lvl;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] level_d;
  logic [VEC_W-1:0] vector_d;

  irq_eligible #(.N(N_SRC)) u_elig (
    .pend(pend_i), .frc(force_i), .en(en_i), .msk(mask_i), .elig(elig)
  );

  irq_tree #(.N(N_SRC), .LVL_W(LVL_W)) u_tree (
    .elig(elig), .lvl_flat(lvl_i), .any(any), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  assign level_d  = any ? win_lvl : '0;
  assign vector_d = any ? (BASE_V + VEC_W'(win_idx)) : SPUR_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      level_o  <= '0;
      vector_o <= SPUR_V;
    end else begin
      valid_o  <= any;
      level_o  <= level_d;
      vector_o <= vector_d;
    end
  end

  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(elig[win_idx])); // R1

  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (vector_o >= BASE_V && vector_o <= LAST_V)); // R4

  AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (vector_o == SPUR_V && level_o == '0)); // R5

  AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
    (|elig) |=> valid_o); // R7

  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(|elig) |=> !valid_o); // R7
endmodule

// File: tb/sim_irq_level_resolver.sv
module sim_irq_level_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 64;
  localparam int LW = 8;
  localparam int VW = 8;

  typedef struct packed {
    logic          v;
    logic [LW-1:0] l;
    logic [VW-1:0] vec;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    pend = '0, frc = '0, en = '0, msk = '0;
  logic [N*LW-1:0] lvl = '0;
  logic [N-1:0]    s_pend = '0, s_frc = '0, s_en = '0, s_msk = '0;
  logic [N*LW-1:0] s_lvl = '0;
  logic          valid_o;
  logic [LW-1:0] level_o;
  logic [VW-1:0] vector_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];

  irq_level_resolver u0 (
    .clk(clk), .rst(rst), .pend_i(pend), .force_i(frc), .en_i(en),
    .mask_i(msk), .lvl_i(lvl), .valid_o(valid_o), .level_o(level_o),
    .vector_o(vector_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t ref_model();
    exp_t r;
    int best = -1;
    logic [LW-1:0] bl = '0;
    for (int i = 0; i < N; i++) begin
      if ((pend[i] | frc[i]) & en[i] & ~msk[i]) begin
        if (best < 0 || lvl[i*LW +: LW] >= bl) begin
          best = i;
          bl = lvl[i*LW +: LW];
        end
      end
    end
    r.v   = (best >= 0);
    r.l   = (best >= 0) ? bl : '0;
    r.vec = (best >= 0) ? VW'(best + 64) : VW'(24);
    return r;
  endfunction

  function automatic exp_t outs();
    exp_t r;
    r.v = valid_o; r.l = level_o; r.vec = vector_o;
    return r;
  endfunction

  task automatic check(string tag, exp_t got, exp_t want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got valid=%0d level=%0d vector=%0d, expected valid=%0d level=%0d vector=%0d",
               tag, got.v, got.l, got.vec, want.v, want.l, want.vec);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic clear_stage();
    s_pend = '0; s_frc = '0; s_en = '0; s_msk = '0; s_lvl = '0;
  endtask

  task automatic set_lvl(int i, logic [LW-1:0] v);
    s_lvl[i*LW +: LW] = v;
  endtask

  // driver: applies staged inputs at a falling edge and queues the expectation
  task automatic apply(string tag);
    @(negedge clk);
    pend = s_pend; frc = s_frc; en = s_en; msk = s_msk; lvl = s_lvl;
    exp_q.push_back(ref_model());
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  // monitor: results of the previous falling-edge stimulus appear at this rising edge
  always @(posedge clk) begin
    #2;
    if (!rst && exp_q.size() > 0) begin
      check(tag_q.pop_front(), outs(), exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: got hung run, expected completion");
    finish_run();
  end

  initial begin
    exp_t e;
    // R8: reset with live requests present
    pend = '1; en = '1; lvl = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e = '{v: 1'b0, l: '0, vec: VW'(24)};
    check("R8 reset state", outs(), e);
    pend = '0; en = '0; lvl = '0;
    rst = 1'b0;

    clear_stage();
    apply("R5 no request");

    clear_stage(); s_pend[5] = 1'b1; s_en[5] = 1'b1; set_lvl(5, 8'd3);
    apply("R4 single source 5");

    clear_stage(); s_pend[63] = 1'b1; s_en[63] = 1'b1; set_lvl(63, 8'd200);
    apply("R4 top source 63");

    clear_stage(); s_pend[7] = 1'b1; s_en[7] = 1'b1; s_msk[7] = 1'b1; set_lvl(7, 8'd9);
    apply("R1 masked pending ignored");

    clear_stage(); s_pend[8] = 1'b1; set_lvl(8, 8'd9);
    apply("R1 disabled pending ignored");

    clear_stage(); s_frc[12] = 1'b1; s_en[12] = 1'b1; set_lvl(12, 8'd4);
    apply("R1 forced source competes");

    clear_stage(); s_frc[13] = 1'b1; s_en[13] = 1'b1; s_msk[13] = 1'b1; set_lvl(13, 8'd4);
    apply("R10 mask overrides force");

    clear_stage(); s_pend[3] = 1'b1; s_en[3] = 1'b1; set_lvl(3, 8'd7);
    s_pend[50] = 1'b1; s_en[50] = 1'b1; set_lvl(50, 8'd2);
    apply("R2 lower index higher level");

    clear_stage(); s_pend[10] = 1'b1; s_en[10] = 1'b1; set_lvl(10, 8'd6);
    s_pend[40] = 1'b1; s_en[40] = 1'b1; set_lvl(40, 8'd6);
    apply("R3 tie to higher index");

    clear_stage(); s_pend = '1; s_en = '1;
    for (int i = 0; i < N; i++) set_lvl(i, 8'd5);
    apply("R3 all tied");

    clear_stage(); s_pend[20] = 1'b1; s_en[20] = 1'b1;
    apply("R9 level zero winner");
    drain();

    // R6: outputs hold between edges, then follow the new inputs
    e = outs();
    @(negedge clk);
    pend = '0; en = '0; lvl = '0; frc = '0; msk = '0;
    pend[33] = 1'b1; en[33] = 1'b1; lvl[33*LW +: LW] = 8'd11;
    #2;
    check("R6 hold before edge", outs(), e);
    @(posedge clk); #2;
    check("R6 update after edge", outs(), '{v: 1'b1, l: 8'd11, vec: VW'(97)});
    check("R7 valid follows request", outs(), ref_model());

    for (int k = 0; k < 300; k++) begin
      s_pend = {$urandom, $urandom};
      s_frc  = {$urandom, $urandom} & {$urandom, $urandom};
      s_en   = {$urandom, $urandom} | {$urandom, $urandom};
      s_msk  = {$urandom, $urandom} & {$urandom, $urandom};
      if (k % 10 == 0) s_en = '0;
      for (int i = 0; i < N; i++) set_lvl(i, LW'($urandom % 4));
      apply("R2 random pattern");
    end
    drain();

    // R8: reset in mid-operation
    clear_stage(); s_pend[1] = 1'b1; s_en[1] = 1'b1; set_lvl(1, 8'd1);
    apply("R2 pre-reset");
    drain();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #2;
    check("R8 mid reset", outs(), '{v: 1'b0, l: '0, vec: VW'(24)});
    @(negedge clk);
    rst = 1'b0;
    apply("R7 after reset");
    drain();

    finish_run();
  end
endmodule